// File: doc/BRIEF.md
# One-Wire Temperature Sequencer

This block runs a fixed measurement loop against a single digital temperature sensor on a one-wire bus. The bus is open-drain: the block either pulls the line low or lets it float high through an external pull-up, and it reads the line level back. Every timing interval is counted in microsecond ticks supplied by a `tick_us` enable, so the block runs from any system clock.

Each loop has two phases. The first phase is a bus reset, a skip-ROM command (0xCC) and a convert command (0x44), followed by a long conversion wait. The second phase is a second reset, 0xCC again, the read-scratchpad command (0xBE), and two read bytes. The two bytes form a 16-bit raw temperature word.

The word leaves through a valid/ready output. `temp_valid` rises with the word and stays high, with `temp_data` unchanged, until `temp_ready` is seen high at a clock edge. While the word is pending the bus stays idle. After the handshake completes, the loop starts again with a new reset. When `temp_ready` is tied high, each word appears as a one-cycle pulse.

Top module: `ow_temp_seq`

## Requirements
- R1: A bus reset pulls the line low for exactly RST_LOW_US ticks (500 by default). It then releases the line for at least RST_REL_US ticks (500) before the next slot begins.
- R2: After every reset, the first byte written is 0xCC. In the first phase, the second byte written is 0x44.
- R3: After the last slot of 0x44 ends, the block waits CONV_WAIT_US ticks (800000 by default) and then starts the second reset.
- R4: A write slot pulls the line low for 5 ticks when the bit is 1, or for 60 ticks when the bit is 0. Every write slot lasts 65 ticks.
- R5: Each byte is sent as eight slots, least significant bit first.
- R6: In the second phase, 0xCC is followed by 0xBE and then by two read bytes.
- R7: A read slot pulls the line low for 3 ticks, samples the line 12 ticks after the slot opens, and lasts 65 ticks.
- R8: Read bits fill each byte starting at bit 0. The first byte read becomes `temp_data[7:0]` and the second becomes `temp_data[15:8]`.
- R9: While `temp_valid` is high and `temp_ready` is low, `temp_valid` stays high and `temp_data` holds its value. When the handshake completes, `temp_valid` falls on the next cycle.
- R10: While a word is pending, the line is never pulled. After the handshake, the next bus activity is a reset.
- R11: The line is only ever pulled low or released. It is released during reset and between slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| ow_line_in | input | 1 | Sensed level of the bus line |
| ow_pull | output | 1 | 1 pulls the bus line low, 0 releases it |
| temp_data | output | 16 | Raw temperature word |
| temp_valid | output | 1 | Temperature word available |
| temp_ready | input | 1 | Consumer accepts the word |

## Verification
The bench ticks every cycle, so every duration in ticks can be checked as an exact count of clock cycles.

- A pull length is checked on the cycle the line is released. Reset lows must last exactly 500 cycles, write lows exactly 5 or 60, and read lows exactly 3.
- Gaps are measured from the moment a pull ends:
  - The gap after a reset must be 500 cycles plus at most a few cycles of hand-off.
  - The gap after the convert byte must be the conversion wait plus at most 16 cycles.
- The sensor model pulls the line for 30 cycles from the negative edge where it sees a read slot open. This covers the sample taken 12 cycles in.
- The scoreboard compares a word on each negative edge where `temp_valid` and `temp_ready` are both high. It then requires `temp_valid` to be low one cycle later.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    SLOT_RESET = 2'd0,
    SLOT_WRITE = 2'd1,
    SLOT_READ  = 2'd2
  } slot_kind_e;

  typedef enum logic [3:0] {
    ST_RST_A, ST_SKIP_A, ST_CONVERT, ST_CONV_WAIT,
    ST_RST_B, ST_SKIP_B, ST_READ_CMD, ST_READ_LO, ST_READ_HI, ST_DELIVER
  } seq_step_e;

  localparam logic [7:0] CMD_SKIP_ROM     = 8'hCC;
  localparam logic [7:0] CMD_CONVERT      = 8'h44;
  localparam logic [7:0] CMD_READ_SCRATCH = 8'hBE;
endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
  import ow_pkg::*;
#(
  parameter int RST_LOW_US   = 500,
  parameter int RST_REL_US   = 500,
  parameter int WR_LOW_US    = 5,
  parameter int WR_DATA_US   = 60,
  parameter int WR_SLOT_US   = 65,
  parameter int RD_LOW_US    = 3,
  parameter int RD_SAMPLE_US = 12,
  parameter int RD_SLOT_US   = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       wbit,
  input  logic       line_in,
  output logic       busy,
  output logic       pull,
  output logic       rbit,
  output logic       done
);
  localparam int RST_SLOT_US = RST_LOW_US + RST_REL_US;
  localparam int CW = $clog2(RST_SLOT_US + WR_SLOT_US + RD_SLOT_US + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  slot_kind_e    kind_q;
  logic          wbit_q;

  always_comb begin
    case (kind_q)
      SLOT_RESET: last = CW'(RST_SLOT_US - 1);
      SLOT_WRITE: last = CW'(WR_SLOT_US - 1);
      default:    last = CW'(RD_SLOT_US - 1);
    endcase
  end

  // line pulled low only in the drive phases of the active slot
  always_comb begin
    pull = 1'b0;
    if (busy) begin
      case (kind_q)
        SLOT_RESET: pull = cnt < CW'(RST_LOW_US);
        SLOT_WRITE: pull = (cnt < CW'(WR_LOW_US)) || (!wbit_q && (cnt < CW'(WR_DATA_US)));
        default:    pull = cnt < CW'(RD_LOW_US);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= SLOT_RESET;
      wbit_q <= 1'b0;
      rbit   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          kind_q <= kind;
          wbit_q <= wbit;
        end
      end else if (tick_us) begin
        if (kind_q == SLOT_READ && cnt == CW'(RD_SAMPLE_US)) rbit <= line_in;
        if (cnt == last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4 R7: every slot opens with the line pulled low
  a_r4_slot_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pull);

  // R7: the sample is taken after the line has been released
  a_r7_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == SLOT_READ && tick_us && cnt == CW'(RD_SAMPLE_US)) |-> !pull);
endmodule

// File: rtl/ow_byte_xfer.sv
module ow_byte_xfer
  import ow_pkg::*;
#(
  parameter int BITS         = 8,
  parameter int RST_LOW_US   = 500,
  parameter int RST_REL_US   = 500,
  parameter int WR_LOW_US    = 5,
  parameter int WR_DATA_US   = 60,
  parameter int WR_SLOT_US   = 65,
  parameter int RD_LOW_US    = 3,
  parameter int RD_SAMPLE_US = 12,
  parameter int RD_SLOT_US   = 65
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_us,
  input  logic            start,
  input  slot_kind_e      op,
  input  logic [BITS-1:0] tx_byte,
  input  logic            line_in,
  output logic            pull,
  output logic [BITS-1:0] rx_byte,
  output logic            done
);
  localparam int NBW = $clog2(BITS);

  logic            active;
  logic            go;
  slot_kind_e      op_q;
  logic [BITS-1:0] sh;
  logic [NBW-1:0]  nbit;
  logic            slot_busy;
  logic            slot_rbit;
  logic            slot_done;

  ow_slot_timer #(
    .RST_LOW_US(RST_LOW_US), .RST_REL_US(RST_REL_US),
    .WR_LOW_US(WR_LOW_US), .WR_DATA_US(WR_DATA_US), .WR_SLOT_US(WR_SLOT_US),
    .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .RD_SLOT_US(RD_SLOT_US)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .start(go), .kind(op_q), .wbit(sh[0]), .line_in(line_in),
    .busy(slot_busy), .pull(pull), .rbit(slot_rbit), .done(slot_done)
  );

  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      go     <= 1'b0;
      done   <= 1'b0;
      op_q   <= SLOT_RESET;
      sh     <= '0;
      nbit   <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          op_q   <= op;
          sh     <= tx_byte;
          nbit   <= '0;
          go     <= 1'b1;
        end
      end else if (slot_done) begin
        // LSB-first: written bit leaves at bit 0, read bit enters at the top
        sh <= {slot_rbit, sh[BITS-1:1]};
        if (op_q == SLOT_RESET || nbit == NBW'(BITS - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          nbit <= nbit + 1'b1;
          go   <= 1'b1;
        end
      end
    end
  end

  // R5: a slot is only launched once the previous one has finished
  a_r5_slot_idle_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !slot_busy);
endmodule

// File: rtl/ow_temp_seq.sv
module ow_temp_seq
  import ow_pkg::*;
#(
  parameter int CONV_WAIT_US = 800000,
  parameter int RST_LOW_US   = 500,
  parameter int RST_REL_US   = 500,
  parameter int WR_LOW_US    = 5,
  parameter int WR_DATA_US   = 60,
  parameter int WR_SLOT_US   = 65,
  parameter int RD_LOW_US    = 3,
  parameter int RD_SAMPLE_US = 12,
  parameter int RD_SLOT_US   = 65
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        ow_line_in,
  output logic        ow_pull,
  output logic [15:0] temp_data,
  output logic        temp_valid,
  input  logic        temp_ready
);
  localparam int BITS = 8;
  localparam int WCW  = $clog2(CONV_WAIT_US + 1);

  seq_step_e       step;
  seq_step_e       nxt;
  logic            launched;
  logic            xstart;
  logic            xdone;
  slot_kind_e      xop;
  logic [BITS-1:0] xtx;
  logic [BITS-1:0] xrx;
  logic [WCW-1:0]  wcnt;

  ow_byte_xfer #(
    .BITS(BITS), .RST_LOW_US(RST_LOW_US), .RST_REL_US(RST_REL_US),
    .WR_LOW_US(WR_LOW_US), .WR_DATA_US(WR_DATA_US), .WR_SLOT_US(WR_SLOT_US),
    .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .RD_SLOT_US(RD_SLOT_US)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .start(xstart), .op(xop), .tx_byte(xtx), .line_in(ow_line_in),
    .pull(ow_pull), .rx_byte(xrx), .done(xdone)
  );

  always_comb begin
    xop = SLOT_WRITE;
    xtx = CMD_SKIP_ROM;
    case (step)
      ST_RST_A, ST_RST_B:     xop = SLOT_RESET;
      ST_CONVERT:             xtx = CMD_CONVERT;
      ST_READ_CMD:            xtx = CMD_READ_SCRATCH;
      ST_READ_LO, ST_READ_HI: begin xop = SLOT_READ; xtx = '1; end
      default: ;
    endcase
  end

  always_comb begin
    case (step)
      ST_RST_A:    nxt = ST_SKIP_A;
      ST_SKIP_A:   nxt = ST_CONVERT;
      ST_CONVERT:  nxt = ST_CONV_WAIT;
      ST_RST_B:    nxt = ST_SKIP_B;
      ST_SKIP_B:   nxt = ST_READ_CMD;
      ST_READ_CMD: nxt = ST_READ_LO;
      ST_READ_LO:  nxt = ST_READ_HI;
      default:     nxt = ST_DELIVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= ST_RST_A;
      launched   <= 1'b0;
      xstart     <= 1'b0;
      wcnt       <= '0;
      temp_data  <= '0;
      temp_valid <= 1'b0;
    end else begin
      xstart <= 1'b0;
      case (step)
        ST_CONV_WAIT: if (tick_us) begin
          if (wcnt == WCW'(CONV_WAIT_US - 1)) begin
            wcnt <= '0;
            step <= ST_RST_B;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_DELIVER: if (temp_ready) begin
          temp_valid <= 1'b0;
          step       <= ST_RST_A;
        end
        default: if (!launched) begin
          xstart   <= 1'b1;
          launched <= 1'b1;
        end else if (xdone) begin
          launched <= 1'b0;
          step     <= nxt;
          if (step == ST_READ_LO) temp_data[7:0] <= xrx;
          if (step == ST_READ_HI) begin
            temp_data[15:8] <= xrx;
            temp_valid      <= 1'b1;
          end
        end
      endcase
    end
  end

  // R9: a pending word is held steady until accepted
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && !temp_ready) |=> (temp_valid && $stable(temp_data)));

  // R9: an accepted word is withdrawn on the next cycle
  a_r9_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && temp_ready) |=> !temp_valid);

  // R10: the bus stays released while a word waits
  a_r10_quiet_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |-> !ow_pull);
endmodule

// File: tb/ow_temp_seq_test.sv
module ow_temp_seq_test;
  localparam int CONV = 200;
  localparam int RLOW = 500;
  localparam int RREL = 500;
  localparam int NWORDS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic temp_ready = 1'b1;
  logic sensor_pull = 1'b0;
  logic ow_pull;
  logic temp_valid;
  logic [15:0] temp_data;
  logic line;

  assign line = !(ow_pull || sensor_pull);
  always #2 clk = ~clk;

  ow_temp_seq #(.CONV_WAIT_US(CONV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ow_line_in(line),
    .ow_pull(ow_pull), .temp_data(temp_data), .temp_valid(temp_valid),
    .temp_ready(temp_ready)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] vals [NWORDS] = '{16'h0550, 16'hFC90, 16'hA5C3, 16'h0000, 16'hFFFF};
  logic [15:0] expq [$];
  logic [15:0] exp_v;

  // driver side of the scoreboard: expected word is queued at each conversion
  task automatic push_expected(input logic [15:0] v);
    expq.push_back(v);
  endtask

  // sensor model and bus timing monitor
  int pull_len = 0, since_fall = 0, since_conv = 0, hold = 0;
  int mode = 0, bitc = 0, bytec = 0, nconv = 0, txi = 0;
  bit prev_pull = 0, last_was_reset = 0, conv_armed = 0, expect_conv = 1;
  logic [7:0] rxb = '0;
  logic [15:0] txw = '0;

  always @(negedge clk) if (rst_n) begin
    if (hold > 0) begin
      hold--;
      if (hold == 0) sensor_pull = 1'b0;
    end
    if (ow_pull && !prev_pull) begin
      if (last_was_reset)
        check(since_fall >= RREL && since_fall <= RREL + 6, "R1", "release after reset", since_fall, RREL);
      if (conv_armed) begin
        check(since_conv >= CONV && since_conv <= CONV + 16, "R3", "conversion wait", since_conv, CONV);
        conv_armed = 0;
      end
      last_was_reset = 0;
      if (mode == 2) begin
        sensor_pull = !txw[txi];
        hold = 30;
      end
      pull_len = 1;
    end else if (ow_pull) begin
      pull_len++;
    end else if (prev_pull) begin
      since_fall = 0;
      if (pull_len >= 400) begin
        check(pull_len == RLOW, "R1", "reset low time", pull_len, RLOW);
        mode = 1; bitc = 0; bytec = 0; last_was_reset = 1;
      end else if (mode == 1) begin
        check(pull_len == 5 || pull_len == 60, "R4", "write low time", pull_len, (pull_len < 30) ? 5 : 60);
        rxb = {pull_len < 30, rxb[7:1]};
        bitc++;
        if (bitc == 8) begin
          bitc = 0;
          if (bytec == 0) check(rxb == 8'hCC, "R2,R5", "skip command", rxb, 8'hCC);
          else if (expect_conv) check(rxb == 8'h44, "R2,R5", "convert command", rxb, 8'h44);
          else check(rxb == 8'hBE, "R6", "read command", rxb, 8'hBE);
          if (bytec == 1) begin
            if (rxb == 8'h44) begin
              txw = vals[nconv % NWORDS];
              push_expected(txw);
              nconv++;
              conv_armed = 1;
              since_conv = 0;
              mode = 0;
            end else if (rxb == 8'hBE) begin
              mode = 2; txi = 0;
            end else begin
              mode = 0;
            end
            expect_conv = !expect_conv;
          end
          bytec++;
        end
      end else if (mode == 2) begin
        check(pull_len == 3, "R7", "read low time", pull_len, 3);
        txi++;
        if (txi == 16) mode = 0;
      end
    end
    prev_pull = ow_pull;
    since_fall++;
    since_conv++;
  end

  // scoreboard monitor
  bit prev_acc = 0;
  int got = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_acc) check(!temp_valid, "R9", "valid after accept", temp_valid, 0);
    prev_acc = temp_valid && temp_ready;
    if (temp_valid && temp_ready) begin
      if (expq.size() == 0) begin
        check(0, "R8", "unexpected word", temp_data, 0);
      end else begin
        exp_v = expq.pop_front();
        check(temp_data == exp_v, "R8", "temperature word", temp_data, exp_v);
      end
      got++;
    end
  end

  logic [15:0] held;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ow_pull == 1'b0, "R11", "line released in reset", ow_pull, 0);
    check(temp_valid == 1'b0, "R9", "valid low in reset", temp_valid, 0);
    @(negedge clk) rst_n = 1'b1;
    wait (got == 1);
    @(negedge clk) temp_ready = 1'b0;
    wait (temp_valid);
    @(negedge clk);
    held = temp_data;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(temp_valid == 1'b1, "R9", "valid held", temp_valid, 1);
      check(temp_data == held, "R9", "data held", temp_data, held);
      check(ow_pull == 1'b0, "R10", "bus quiet while pending", ow_pull, 0);
      check(line == 1'b1, "R11", "line released while pending", line, 1);
    end
    temp_ready = 1'b1;
    wait (got == NWORDS);
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R8", "all words delivered", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=%0d words expected=%0d", got, NWORDS);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule